// File: doc/BRIEF.md
# FSK Receive Character Deframer with Serial Readout

This block sits behind a 1200 baud FSK demodulator and turns the recovered line level into asynchronous characters. Each character on the line is a low start bit, seven data bits, a parity bit and a high stop bit. The line is oversampled on a baud tick enable that runs at 16 times the bit rate. Each bit value is the majority of three samples taken around the middle of the bit. A start edge counts only if the line is still low in the middle of the start bit.

A finished character goes into a single holding register and raises a ready flag. The host then clocks the character out one bit per rising edge of its acknowledge clock. The first data bit is presented first, the parity bit last. The eighth edge clears the ready flag. A control input can hold the ready flag low without losing the held character.

The seizure pattern and mark runs that come before a message pass through as ordinary characters, or leave the block idle. Parity is delivered to the host and not checked.

Top module: `fsk_rx_deframer`

## Requirements
- R1: A frame is a 0 start bit, data bits b1..b7, parity P and a 1 stop bit, all sent in that order. The held word keeps b1 in bit 0, b7 in bit 6 and P in bit 7.
- R2: Characters are received correctly when the bit period differs from the nominal 16 ticks by up to ±1.6%.
- R3: `data_ready` rises after a valid stop bit. It falls only after the eighth rising edge of `ack` following that character.
- R4: `data_out` shows b1 while `data_ready` is high. Each rising edge of `ack` moves it to the next bit, through b7 and then P.
- R5: A stop bit sampled as 0 gives a one-cycle `frame_err` pulse. The character is dropped and `data_ready` stays low. The receiver does not look for a new start bit until the line has been high again.
- R6: A low level that has ended before the middle of the start bit does not start a character.
- R7: While `dr_inhibit` is high, `data_ready` is low. A character received during that time is kept, and it shows on `data_ready` once `dr_inhibit` goes low.
- R8: If a character completes before the previous one has been fully read, the new one replaces it and `overrun` goes high. `overrun` clears when a readout completes.
- R9: A disturbance that corrupts one of the three mid-bit samples does not change the bit value received.
- R10: After reset, `data_ready`, `overrun`, `frame_err` and `data_out` are 0.
- R11: `ack` edges while no character is held have no effect. The next character still reads out from b1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_line | input | 1 | Demodulated line level (mark = 1) |
| dr_inhibit | input | 1 | High holds `data_ready` low |
| ack | input | 1 | Host readout clock, rising edge advances |
| data_ready | output | 1 | A character is held and unread |
| data_out | output | 1 | Current readout bit |
| overrun | output | 1 | An unread character was overwritten |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
A wrong tick counter or bit index moves every later sample. The error shows as a wrong or shifted word on `data_out` within the same character, and worst at the slow and fast bit rates. A stuck framer state shows as a missing `data_ready` one frame time after a start, or as a spurious `frame_err`. A readout index that resets or advances wrongly shows within eight `ack` edges, as swapped bits or a ready flag that clears too early or too late. An overrun flag that sets or clears wrongly is visible as soon as two characters arrive without a read in between.

// File: rtl/fskrx_pkg.sv
package fskrx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_FRAME  = 2'd1,
    RX_WAITHI = 2'd2
  } rx_state_e;

  // Two-of-three vote over mid-bit samples.
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/fskrx_framer.sv
module fskrx_framer
  import fskrx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int CHAR_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx,
  output logic                 char_done,
  output logic                 frame_err,
  output logic [CHAR_BITS-1:0] word
);
  localparam int CW         = $clog2(OVERSAMPLE);
  localparam int MID        = OVERSAMPLE / 2;
  localparam int FRAME_BITS = CHAR_BITS + 2;
  localparam int BW         = $clog2(FRAME_BITS + 1);
  localparam int STOP_IDX   = FRAME_BITS - 1;

  rx_state_e            state;
  logic [CW-1:0]        tick_cnt;
  logic [BW-1:0]        bit_idx;
  logic [1:0]           samp;
  logic [CHAR_BITS-1:0] shreg;
  logic                 decide;
  logic                 bit_val;
  logic                 in_window;

  assign in_window = (int'(tick_cnt) >= MID - 1) && (int'(tick_cnt) <= MID);
  assign decide    = tick && (state == RX_FRAME) && (int'(tick_cnt) == MID + 1);
  assign bit_val   = vote3({samp, rx});
  assign word      = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      tick_cnt  <= '0;
      bit_idx   <= '0;
      samp      <= '0;
      shreg     <= '0;
      char_done <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      char_done <= 1'b0;
      frame_err <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rx) begin
              state    <= RX_FRAME;
              tick_cnt <= '0;
              bit_idx  <= '0;
            end
          end
          RX_WAITHI: begin
            if (rx) state <= RX_IDLE;
          end
          default: begin
            if (int'(tick_cnt) == OVERSAMPLE - 1) begin
              tick_cnt <= '0;
              bit_idx  <= bit_idx + 1'b1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
            if (in_window) samp <= {samp[0], rx};
            if (decide) begin
              if (bit_idx == '0) begin
                if (bit_val) state <= RX_IDLE;
              end else if (int'(bit_idx) < STOP_IDX) begin
                shreg <= {bit_val, shreg[CHAR_BITS-1:1]};
              end else begin
                if (bit_val) begin
                  state     <= RX_IDLE;
                  char_done <= 1'b1;
                end else begin
                  state     <= RX_WAITHI;
                  frame_err <= 1'b1;
                end
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fskrx_readout.sv
module fskrx_readout #(
  parameter int CHAR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [CHAR_BITS-1:0] word,
  input  logic                 ack_rise,
  output logic                 full,
  output logic                 bit_out,
  output logic                 overrun,
  output logic                 read_done
);
  localparam int IW = $clog2(CHAR_BITS);

  logic [CHAR_BITS-1:0] hold;
  logic [IW-1:0]        rd_idx;
  logic                 last;

  assign last      = (int'(rd_idx) == CHAR_BITS - 1);
  assign read_done = full && ack_rise && last;
  assign bit_out   = hold[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      rd_idx  <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else if (load) begin
      hold    <= word;
      rd_idx  <= '0;
      full    <= 1'b1;
      overrun <= full && !read_done;
    end else begin
      if (read_done) begin
        full    <= 1'b0;
        overrun <= 1'b0;
        rd_idx  <= '0;
      end else if (full && ack_rise) begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_rx_deframer.sv
module fsk_rx_deframer #(
  parameter int OVERSAMPLE = 16,
  parameter int CHAR_BITS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic rx_line,
  input  logic dr_inhibit,
  input  logic ack,
  output logic data_ready,
  output logic data_out,
  output logic overrun,
  output logic frame_err
);
  logic [1:0]           rx_sync;
  logic [2:0]           ack_sync;
  logic                 ack_rise;
  logic                 char_done_w;
  logic                 frame_err_w;
  logic [CHAR_BITS-1:0] word_w;
  logic                 full_w;
  logic                 read_done_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync  <= 2'b11;
      ack_sync <= 3'b000;
    end else begin
      rx_sync  <= {rx_sync[0], rx_line};
      ack_sync <= {ack_sync[1:0], ack};
    end
  end

  assign ack_rise = ack_sync[1] & ~ack_sync[2];

  fskrx_framer #(.OVERSAMPLE(OVERSAMPLE), .CHAR_BITS(CHAR_BITS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .rx        (rx_sync[1]),
    .char_done (char_done_w),
    .frame_err (frame_err_w),
    .word      (word_w)
  );

  fskrx_readout #(.CHAR_BITS(CHAR_BITS)) u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (char_done_w),
    .word      (word_w),
    .ack_rise  (ack_rise),
    .full      (full_w),
    .bit_out   (data_out),
    .overrun   (overrun),
    .read_done (read_done_w)
  );

  assign data_ready = full_w & ~dr_inhibit;
  assign frame_err  = frame_err_w;
endmodule

// File: rtl/fskrx_checks.sv
module fskrx_checks (
  input logic clk,
  input logic rst_n,
  input logic dr_inhibit,
  input logic data_ready,
  input logic overrun,
  input logic char_done,
  input logic frame_err,
  input logic full,
  input logic read_done
);
  // R3
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(data_ready) && !dr_inhibit) |-> $past(read_done));

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> ($past(char_done) || $past(dr_inhibit)));

  // R5
  done_xor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({char_done, frame_err}));

  // R5
  err_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !full) |=> !full);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && full && !read_done) |=> overrun);

  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !char_done) |=> !overrun);
endmodule

bind fsk_rx_deframer fskrx_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .dr_inhibit (dr_inhibit),
  .data_ready (data_ready),
  .overrun    (overrun),
  .char_done  (char_done_w),
  .frame_err  (frame_err_w),
  .full       (full_w),
  .read_done  (read_done_w)
);

// File: tb/fsk_rx_deframer_test.sv
module fsk_rx_deframer_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic rx_line = 1'b1;
  logic dr_inhibit = 1'b0;
  logic ack = 1'b0;
  logic data_ready, data_out, overrun, frame_err;

  int checks = 0;
  int fails = 0;
  int fe_cnt = 0;
  int tdiv = 0;
  bit mon_en = 1'b0;
  logic [7:0] exp_q[$];

  fsk_rx_deframer uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .dr_inhibit(dr_inhibit), .ack(ack), .data_ready(data_ready),
    .data_out(data_out), .overrun(overrun), .frame_err(frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV - 1);
    if (rst_n && frame_err) fe_cnt <= fe_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit: data bit index 1..8 disturbed at its centre, 0 = none
  task automatic send_char(input logic [7:0] w, input logic stopv, input int bclk,
                           input bit push, input int glitch_bit);
    if (push) exp_q.push_back(w);
    drive(1'b0, bclk);
    for (int i = 0; i < 8; i++) begin
      if (glitch_bit == i + 1) begin
        drive(w[i], bclk/2 - 2);
        drive(~w[i], TICK_DIV);
        drive(w[i], bclk - bclk/2 - 2);
      end else begin
        drive(w[i], bclk);
      end
    end
    drive(stopv, bclk);
    drive(1'b1, bclk);
  endtask

  task automatic read_char(output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      got[i] = data_out;
      ack = 1'b1;
      repeat (3) @(negedge clk);
      ack = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic ack_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ack = 1'b1;
      repeat (3) @(negedge clk);
      ack = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  // Scoreboard monitor
  initial begin
    logic [7:0] got;
    logic [7:0] exp;
    forever begin
      wait (mon_en && data_ready);
      read_char(got);
      repeat (3) @(negedge clk);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected character", got, 0);
      end else begin
        exp = exp_q.pop_front();
        chk(got == exp, "R1 R4 character value", got, exp);
      end
      chk(data_ready == 1'b0, "R3 ready cleared by eighth ack", data_ready, 0);
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    int fe0;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(data_ready == 0 && overrun == 0 && frame_err == 0 && data_out == 0,
        "R10 reset outputs", {data_ready, overrun, frame_err, data_out}, 0);
    rst_n = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // R1 R4 R2 R9 scoreboard phase
    mon_en = 1'b1;
    send_char(8'hA5, 1'b1, BIT_CLKS, 1, 0);
    send_char(8'h3C, 1'b1, BIT_CLKS, 1, 0);
    send_char(8'h55, 1'b1, BIT_CLKS - 1, 1, 0);   // R2 fast
    send_char(8'hAA, 1'b1, BIT_CLKS + 1, 1, 0);   // R2 slow
    send_char(8'h81, 1'b1, BIT_CLKS + 1, 1, 0);   // R2 slow
    send_char(8'h7E, 1'b1, BIT_CLKS - 1, 1, 0);   // R2 fast
    send_char(8'hF0, 1'b1, BIT_CLKS, 1, 3);       // R9 glitch on b3
    send_char(8'h0F, 1'b1, BIT_CLKS, 1, 8);       // R9 glitch on P
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (120) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all scoreboard characters delivered", exp_q.size(), 0);
    mon_en = 1'b0;
    repeat (20) @(negedge clk);

    // R5 framing error
    fe0 = fe_cnt;
    send_char(8'h12, 1'b0, BIT_CLKS, 0, 0);
    repeat (BIT_CLKS) @(negedge clk);
    chk(fe_cnt == fe0 + 1, "R5 frame_err pulse", fe_cnt - fe0, 1);
    chk(data_ready == 0, "R5 char discarded", data_ready, 0);

    // R6 short start glitch
    fe0 = fe_cnt;
    drive(1'b0, 12);
    drive(1'b1, 11 * BIT_CLKS);
    chk(data_ready == 0 && fe_cnt == fe0, "R6 short low ignored", data_ready, 0);

    // R11 ack with nothing held
    ack_pulses(3);
    send_char(8'hC3, 1'b1, BIT_CLKS, 0, 0);
    repeat (10) @(negedge clk);
    chk(data_ready == 1, "R3 ready after valid char", data_ready, 1);
    read_char(got);
    chk(got == 8'hC3, "R11 idle acks ignored", got, 8'hC3);

    // R7 inhibit
    dr_inhibit = 1'b1;
    send_char(8'h69, 1'b1, BIT_CLKS, 0, 0);
    repeat (10) @(negedge clk);
    chk(data_ready == 0, "R7 ready held low", data_ready, 0);
    dr_inhibit = 1'b0;
    @(negedge clk);
    chk(data_ready == 1, "R7 ready after release", data_ready, 1);
    read_char(got);
    chk(got == 8'h69, "R7 kept character", got, 8'h69);

    // R8 overrun
    send_char(8'h11, 1'b1, BIT_CLKS, 0, 0);
    chk(overrun == 0, "R8 no overrun on single char", overrun, 0);
    send_char(8'hE2, 1'b1, BIT_CLKS, 0, 0);
    chk(overrun == 1, "R8 overrun set", overrun, 1);
    read_char(got);
    repeat (3) @(negedge clk);
    chk(got == 8'hE2, "R8 newer char kept", got, 8'hE2);
    chk(overrun == 0 && data_ready == 0, "R8 overrun cleared by readout",
        {overrun, data_ready}, 0);

    finish_run();
  end
endmodule